// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Controller

This block sits behind the clock dividers of a system clock generator and decides, cycle by cycle, which clock groups reach the outputs. There are four groups: a processor group, a stoppable bus group, a free-running copy of the bus clock and a reference clock. Two active-low stop inputs turn off the processor group and the stoppable bus group. One active-low power-down input turns off all four groups. All three inputs are asynchronous. Each stop request is first passed through a two-flop metastability guard. It is then advanced only on falling edges of the source clock it controls. A group can therefore turn off or on only between two of its own pulses.

The block runs on one fast system clock and oversamples the divided source clocks. Every output is a register. It carries its source delayed by two system clocks, ANDed with a group enable that changes only while the source is low. Stopped clocks therefore rest low, and the first pulse after a restart is always a whole high phase. A dwell counter for each group keeps a newly enabled group running for a minimum number of pulses before a stop is honoured. Power-down is not held by the dwell counter.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, and after it until a group is first enabled, every output is low.
- R2: Each gated output equals its source clock delayed by two system clocks, or is low. Every high pulse it emits is exactly as long as the source high phase, and it only becomes low on a source falling edge.
- R3: `pci_stop_n` is sampled by two system-clock flops. The synchronized level is applied at the next falling edge of `pci_src` (low = stop, high = run). Only `pci_clk` is affected.
- R4: `cpu_stop_n` is sampled by two system-clock flops and then by two stages clocked on falling edges of `cpu_src`. It takes effect on the third such falling edge. Only `cpu_clk` is affected.
- R5: `pci_free` and `ref_clk` keep running whatever the levels of `cpu_stop_n` and `pci_stop_n`.
- R6: Once `pci_clk` is enabled it emits at least PCI_MIN_ON (default 10) pulses before a stop is honoured. If a stop is requested right after the restart, exactly that many pulses are emitted.
- R7: Once `cpu_clk` is enabled it emits at least CPU_MIN_ON (default 100) pulses before a stop is honoured. If a stop is requested right after the restart, exactly that many pulses are emitted.
- R8: `pd_n` low, after two-flop synchronization, turns off every group at the next falling edge of its own source, regardless of dwell. When `pd_n` returns high, each group restarts at its next source falling edge unless a stop is requested.
- R9: All bits of `cpu_clk` are identical in every cycle, and all bits of `pci_clk` are identical in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the source clocks |
| rst | input | 1 | Synchronous active-high reset |
| cpu_src | input | 1 | Divided processor source clock |
| pci_src | input | 1 | Divided bus source clock |
| ref_src | input | 1 | Reference source clock |
| cpu_stop_n | input | 1 | Asynchronous processor stop request, active low |
| pci_stop_n | input | 1 | Asynchronous bus stop request, active low |
| pd_n | input | 1 | Asynchronous power-down, active low |
| cpu_clk | output | NCPU | Gated processor clock lanes |
| pci_clk | output | NPCI | Gated bus clock lanes |
| pci_free | output | 1 | Bus clock, stopped only by power-down |
| ref_clk | output | 1 | Reference clock, stopped only by power-down |

## Verification
On every cycle, the assertions check three things. First, each output rises and falls only two system clocks after the matching edge of its source, which rules out runt pulses. Second, a processor or bus burst never ends short of its dwell unless power-down intervened. Third, a settled power-down leaves every output low. The exact cycle in which a stop or a restart lands depends on the synchronizer and on the falling-edge pipeline. The behavioural model in the bench compares that cycle on every clock. Only the bench scenarios show that a stop leaves the other groups running, that a burst started under an immediate stop stops at exactly the dwell count, and that outputs come back after power-down.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NGRP     = 4;
  localparam int GRP_CPU  = 0;
  localparam int GRP_PCI  = 1;
  localparam int GRP_FREE = 2;
  localparam int GRP_REF  = 3;
  localparam int SYNC_DEPTH = 2;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int DEPTH = clkstop_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int STAGES = 0,
  parameter int MIN_ON = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic stop_n,
  input  logic pd_ok,
  output logic gclk
);
  logic stop_s;
  logic src_q, src_qq;
  logic fall;
  logic req;
  logic en;
  logic dwell_ok;

  clkstop_sync u_sync (
    .clk (clk),
    .rst (rst),
    .d   (stop_n),
    .q   (stop_s)
  );

  // falling edge of the sampled source: the only moment the enable may move
  assign fall = src_qq & ~src_q;

  if (STAGES == 0) begin : g_direct
    assign req = stop_s;
  end else begin : g_pipe
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '0;
      end else if (fall) begin
        pipe[0] <= stop_s;
        for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign req = pipe[STAGES-1];
  end

  if (MIN_ON <= 1) begin : g_nodwell
    assign dwell_ok = 1'b1;
  end else begin : g_dwell
    localparam int CW = clkstop_pkg::cnt_width(MIN_ON);
    localparam logic [CW-1:0] LAST = CW'(MIN_ON - 1);
    logic [CW-1:0] dwell;
    always_ff @(posedge clk) begin
      if (rst || !en) dwell <= '0;
      else if (fall && dwell != LAST) dwell <= dwell + 1'b1;
    end
    assign dwell_ok = (dwell == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= 1'b0;
      src_qq <= 1'b0;
      en     <= 1'b0;
      gclk   <= 1'b0;
    end else begin
      src_q  <= src;
      src_qq <= src_q;
      gclk   <= src_q & en;
      if (fall) begin
        if (!pd_ok)                 en <= 1'b0;
        else if (!en)               en <= req;
        else if (!req && dwell_ok)  en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int NCPU       = 2,
  parameter int NPCI       = 5,
  parameter int CPU_STAGES = 2,
  parameter int PCI_STAGES = 0,
  parameter int CPU_MIN_ON = 100,
  parameter int PCI_MIN_ON = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_src,
  input  logic            pci_src,
  input  logic            ref_src,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            pd_n,
  output logic [NCPU-1:0] cpu_clk,
  output logic [NPCI-1:0] pci_clk,
  output logic            pci_free,
  output logic            ref_clk
);
  import clkstop_pkg::*;

  logic            pd_ok;
  logic [NGRP-1:0] src_v;
  logic [NGRP-1:0] stop_v;
  logic [NGRP-1:0] gclk_v;

  clkstop_sync u_pd_sync (
    .clk (clk),
    .rst (rst),
    .d   (pd_n),
    .q   (pd_ok)
  );

  assign src_v  = {ref_src, pci_src, pci_src, cpu_src};
  assign stop_v = {1'b1, 1'b1, pci_stop_n, cpu_stop_n};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int ST = (g == GRP_CPU) ? CPU_STAGES :
                        (g == GRP_PCI) ? PCI_STAGES : 0;
    localparam int MO = (g == GRP_CPU) ? CPU_MIN_ON :
                        (g == GRP_PCI) ? PCI_MIN_ON : 0;
    clkstop_gate #(
      .STAGES (ST),
      .MIN_ON (MO)
    ) u_gate (
      .clk    (clk),
      .rst    (rst),
      .src    (src_v[g]),
      .stop_n (stop_v[g]),
      .pd_ok  (pd_ok),
      .gclk   (gclk_v[g])
    );
  end

  assign cpu_clk  = {NCPU{gclk_v[GRP_CPU]}};
  assign pci_clk  = {NPCI{gclk_v[GRP_PCI]}};
  assign pci_free = gclk_v[GRP_FREE];
  assign ref_clk  = gclk_v[GRP_REF];
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NCPU       = 2,
  parameter int NPCI       = 5,
  parameter int CPU_MIN_ON = 100,
  parameter int PCI_MIN_ON = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_src,
  input logic            pci_src,
  input logic            ref_src,
  input logic            pd_ok,
  input logic [NCPU-1:0] cpu_clk,
  input logic [NPCI-1:0] pci_clk,
  input logic            pci_free,
  input logic            ref_clk
);
  logic [2:0] ch, ph, rh;
  logic       cpu_prev, pci_prev;
  int         cpu_burst, pci_burst;
  logic       cpu_pd_seen, pci_pd_seen;
  logic       seen_c, seen_p, seen_r, pd_settled;
  logic       cpu_miss, pci_miss;

  assign cpu_miss = ch[1] & ~ch[2] & ~cpu_clk[0];
  assign pci_miss = ph[1] & ~ph[2] & ~pci_clk[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ch <= '0; ph <= '0; rh <= '0;
      cpu_prev <= 1'b0; pci_prev <= 1'b0;
      cpu_burst <= 0; pci_burst <= 0;
      cpu_pd_seen <= 1'b0; pci_pd_seen <= 1'b0;
      seen_c <= 1'b0; seen_p <= 1'b0; seen_r <= 1'b0;
      pd_settled <= 1'b0;
    end else begin
      ch <= {ch[1:0], cpu_src};
      ph <= {ph[1:0], pci_src};
      rh <= {rh[1:0], ref_src};
      cpu_prev <= cpu_clk[0];
      pci_prev <= pci_clk[0];
      if (cpu_miss) begin
        cpu_burst <= 0; cpu_pd_seen <= !pd_ok;
      end else begin
        if (cpu_clk[0] && !cpu_prev) cpu_burst <= cpu_burst + 1;
        if (!pd_ok) cpu_pd_seen <= 1'b1;
      end
      if (pci_miss) begin
        pci_burst <= 0; pci_pd_seen <= !pd_ok;
      end else begin
        if (pci_clk[0] && !pci_prev) pci_burst <= pci_burst + 1;
        if (!pd_ok) pci_pd_seen <= 1'b1;
      end
      if (pd_ok) begin
        seen_c <= 1'b0; seen_p <= 1'b0; seen_r <= 1'b0;
      end else begin
        if (ch[0] && !cpu_src) seen_c <= 1'b1;
        if (ph[0] && !pci_src) seen_p <= 1'b1;
        if (rh[0] && !ref_src) seen_r <= 1'b1;
      end
      pd_settled <= seen_c & seen_p & seen_r & !pd_ok;
    end
  end

  // R2: outputs move only two system clocks after the matching source edge
  p_cpu_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk[0]) |-> ($past(cpu_src, 2) && !$past(cpu_src, 3)));
  p_cpu_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_clk[0]) |-> (!$past(cpu_src, 2) && $past(cpu_src, 3)));
  p_pci_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pci_clk[0]) |-> ($past(pci_src, 2) && !$past(pci_src, 3)));
  p_pci_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(pci_clk[0]) |-> (!$past(pci_src, 2) && $past(pci_src, 3)));
  p_free_high_r2: assert property (@(posedge clk) disable iff (rst)
    pci_free |-> $past(pci_src, 2));
  p_ref_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_clk) |-> ($past(ref_src, 2) && !$past(ref_src, 3)));

  // R6 / R7: a burst ends short only when power-down intervened
  p_pci_dwell_r6: assert property (@(posedge clk) disable iff (rst)
    (pci_miss && pci_burst > 0 && !pci_pd_seen && pd_ok) |-> (pci_burst >= PCI_MIN_ON));
  p_cpu_dwell_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_miss && cpu_burst > 0 && !cpu_pd_seen && pd_ok) |-> (cpu_burst >= CPU_MIN_ON));

  // R8: settled power-down leaves everything low
  p_pd_low_r8: assert property (@(posedge clk) disable iff (rst)
    (pd_settled && !pd_ok) |-> (cpu_clk == '0 && pci_clk == '0 && !pci_free && !ref_clk));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .NCPU       (NCPU),
  .NPCI       (NPCI),
  .CPU_MIN_ON (CPU_MIN_ON),
  .PCI_MIN_ON (PCI_MIN_ON)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_src  (cpu_src),
  .pci_src  (pci_src),
  .ref_src  (ref_src),
  .pd_ok    (pd_ok),
  .cpu_clk  (cpu_clk),
  .pci_clk  (pci_clk),
  .pci_free (pci_free),
  .ref_clk  (ref_clk)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
  localparam int NCPU = 2;
  localparam int NPCI = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_src = 1'b0, pci_src = 1'b0, ref_src = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
  logic [NCPU-1:0] cpu_clk;
  logic [NPCI-1:0] pci_clk;
  logic pci_free, ref_clk;

  int checks = 0;
  int errors = 0;
  int t = 0;

  clkstop_ctrl #(.NCPU(NCPU), .NPCI(NPCI)) i_clkstop_ctrl (
    .clk(clk), .rst(rst), .cpu_src(cpu_src), .pci_src(pci_src), .ref_src(ref_src),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pd_n(pd_n),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free(pci_free), .ref_clk(ref_clk)
  );

  always #10 clk = ~clk;

  // divided sources: cpu period 4, pci period 8 (aligned), ref period 6
  initial forever begin
    @(negedge clk);
    t++;
    cpu_src = (t % 4) < 2;
    pci_src = (t % 8) < 4;
    ref_src = (t % 6) < 3;
  end

  // ---------------- behavioural reference model ----------------
  int  STG[4]  = '{2, 0, 0, 0};
  int  MINO[4] = '{100, 10, 0, 0};
  int  HALF[4] = '{2, 4, 4, 3};
  bit  ms0[4], ms1[4], s[4], sp[4], en[4], mout[4];
  bit  pq[4][4];
  int  cnt[4];
  bit  mpd0, mpd1;
  bit  fl, rq, ok, sv, stv;

  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < 4; g++) begin
        ms0[g] = 0; ms1[g] = 0; s[g] = 0; sp[g] = 0; en[g] = 0; mout[g] = 0; cnt[g] = 0;
        for (int i = 0; i < 4; i++) pq[g][i] = 0;
      end
      mpd0 = 0; mpd1 = 0;
    end else begin
      for (int g = 0; g < 4; g++) begin
        case (g)
          0: begin sv = cpu_src; stv = cpu_stop_n; end
          1: begin sv = pci_src; stv = pci_stop_n; end
          2: begin sv = pci_src; stv = 1'b1; end
          default: begin sv = ref_src; stv = 1'b1; end
        endcase
        fl = sp[g] & ~s[g];
        rq = (STG[g] == 0) ? ms1[g] : pq[g][STG[g]-1];
        ok = (MINO[g] <= 1) || (cnt[g] >= MINO[g] - 1);
        mout[g] = s[g] & en[g];
        if (fl) begin
          for (int i = 3; i > 0; i--) pq[g][i] = pq[g][i-1];
          pq[g][0] = ms1[g];
          if (!mpd1) en[g] = 0;
          else if (!en[g]) begin en[g] = rq; cnt[g] = 0; end
          else if (!rq && ok) en[g] = 0;
          else if (cnt[g] < MINO[g] - 1) cnt[g]++;
        end
        sp[g] = s[g]; s[g] = sv; ms1[g] = ms0[g]; ms0[g] = stv;
      end
      mpd1 = mpd0; mpd0 = pd_n;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int hi_run[4];
  bit obs[4];
  string tagc[4] = '{"R4", "R3", "R5", "R5"};
  always @(negedge clk) begin
    if (!rst) begin
      obs[0] = cpu_clk[0]; obs[1] = pci_clk[0]; obs[2] = pci_free; obs[3] = ref_clk;
      for (int g = 0; g < 4; g++) begin
        checks++;
        if (obs[g] !== mout[g]) begin
          errors++;
          $display("FAIL %s group %0d cycle %0d actual %b expected %b", tagc[g], g, t, obs[g], mout[g]);
        end
        if (obs[g]) hi_run[g]++;
        else if (hi_run[g] > 0) begin
          checks++;
          if (hi_run[g] != HALF[g]) begin
            errors++;
            $display("FAIL R2 high pulse group %0d actual %0d expected %0d", g, hi_run[g], HALF[g]);
          end
          hi_run[g] = 0;
        end
      end
      checks++;
      if (cpu_clk !== {NCPU{cpu_clk[0]}} || pci_clk !== {NPCI{pci_clk[0]}}) begin
        errors++;
        $display("FAIL R9 lanes actual %b/%b expected uniform", cpu_clk, pci_clk);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic count_rises(input int sel, input int n, output int c);
    bit prev, cur;
    c = 0;
    @(negedge clk);
    prev = (sel == 0) ? cpu_clk[0] : (sel == 1) ? pci_clk[0] : (sel == 2) ? pci_free : ref_clk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = (sel == 0) ? cpu_clk[0] : (sel == 1) ? pci_clk[0] : (sel == 2) ? pci_free : ref_clk;
      if (cur && !prev) c++;
      prev = cur;
    end
  endtask

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_rise(input int sel);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (((sel == 0) ? cpu_clk[0] : pci_clk[0]) == 1'b1) return;
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected completion");
    finish_run();
  end

  int c;
  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    expect_eq("R1", "outputs in reset", {cpu_clk, pci_clk, pci_free, ref_clk}, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1", "outputs just after reset", {cpu_clk, pci_clk, pci_free, ref_clk}, 0);
    repeat (450) @(negedge clk);
    count_rises(2, 40, c); expect_eq("R5", "free rises while running", c, 5);
    count_rises(0, 32, c); expect_eq("R4", "cpu rises while running", c, 8);

    // PCI stop only
    pci_stop_n = 1'b0;
    repeat (40) @(negedge clk);
    count_rises(1, 32, c); expect_eq("R3", "pci rises while stopped", c, 0);
    count_rises(2, 32, c); expect_eq("R5", "free rises during pci stop", c, 4);
    count_rises(0, 32, c); expect_eq("R3", "cpu rises during pci stop", c, 8);
    pci_stop_n = 1'b1;
    repeat (40) @(negedge clk);
    count_rises(1, 32, c); expect_eq("R3", "pci rises after release", c, 4);

    // CPU stop only
    cpu_stop_n = 1'b0;
    repeat (40) @(negedge clk);
    count_rises(0, 32, c); expect_eq("R4", "cpu rises while stopped", c, 0);
    count_rises(1, 32, c); expect_eq("R4", "pci rises during cpu stop", c, 4);
    count_rises(3, 30, c); expect_eq("R5", "ref rises during cpu stop", c, 5);

    // CPU dwell: restart then stop at once
    cpu_stop_n = 1'b1;
    wait_rise(0);
    cpu_stop_n = 1'b0;
    count_rises(0, 600, c); expect_eq("R7", "cpu pulses after first in burst", c, 99);

    // PCI dwell
    pci_stop_n = 1'b0;
    repeat (100) @(negedge clk);
    pci_stop_n = 1'b1;
    wait_rise(1);
    pci_stop_n = 1'b0;
    count_rises(1, 200, c); expect_eq("R6", "pci pulses after first in burst", c, 9);

    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    repeat (60) @(negedge clk);

    // power-down, issued during a fresh cpu burst
    pd_n = 1'b0;
    repeat (20) @(negedge clk);
    count_rises(0, 30, c); expect_eq("R8", "cpu rises in power-down", c, 0);
    count_rises(1, 30, c); expect_eq("R8", "pci rises in power-down", c, 0);
    count_rises(2, 30, c); expect_eq("R8", "free rises in power-down", c, 0);
    count_rises(3, 30, c); expect_eq("R8", "ref rises in power-down", c, 0);
    pd_n = 1'b1;
    repeat (20) @(negedge clk);
    count_rises(2, 32, c); expect_eq("R8", "free rises after power-up", c, 4);
    count_rises(3, 30, c); expect_eq("R8", "ref rises after power-up", c, 5);
    count_rises(0, 32, c); expect_eq("R8", "cpu rises after power-up", c, 8);

    // narrow request pulses, checked by the model comparison (R3, R4, R8)
    repeat (450) @(negedge clk);
    cpu_stop_n = 1'b0; @(negedge clk); cpu_stop_n = 1'b1;
    repeat (30) @(negedge clk);
    pci_stop_n = 1'b0; @(negedge clk); pci_stop_n = 1'b1;
    repeat (30) @(negedge clk);
    pd_n = 1'b0; @(negedge clk); pd_n = 1'b1;
    repeat (60) @(negedge clk);
    finish_run();
  end
endmodule